// File: doc/BRIEF.md
# Windowed GPIO Configuration Bank

This block holds the configuration of a set of general-purpose pins on a switch-style device. The host reaches it only through one 16-bit window register. The upper byte of the window is a pointer to an internal byte-wide sub-register and the lower byte carries data. Behind the window sit three kinds of byte: per-pin direction bits, per-pin data bits, and 3-bit function-mode fields packed two to a byte.

The block drives each pin's output enable and output value from registered state. Pad inputs are synchronised before the host can read them. Any pin may select a special function: trigger output, event request input, external clock, or one of two receive clocks. For each function the block reports whether some pin claims it and which pin that is. When several pins claim the same function, the lowest-indexed pin is the owner.

The host reads a byte in two steps: it loads the pointer alone, then samples the window. A write sets the pointer and the addressed byte at the same clock edge.

Top module: `gpio_win_bank`

## Requirements
- R1: The window read value `host_rdata` is {pointer, addressed byte}, with the pointer in bits 15:8 and the byte in bits 7:0. Every accepted write loads the pointer from `host_wdata[15:8]` at that clock edge.
- R2: A pointer-only write (`host_ptr_wr` high, `host_wr` low) loads the pointer and changes no configuration byte. After that edge the addressed byte appears in `host_rdata[7:0]`.
- R3: A write (`host_wr` high) stores `host_wdata[7:0]` into the byte named by `host_wdata[15:8]` at that clock edge. When both strobes are high, the write takes effect.
- R4: Direction bits live at sub-addresses 0x62 and 0x63. A pin sits at bit (pin mod 8) of byte 0x62 + pin/8. A value of 1 means input and 0 means output. `pad_oe` is the inverse of the direction bit and updates on the edge after the write.
- R5: Data bits live at 0x64 and 0x65, using the same pin-to-bit mapping as the direction bits. A write sets the stored output value, and `pad_out` shows it after the next edge. A read returns the synchronised pad level for input pins and the stored value for output pins.
- R6: Mode fields live at 0x68 + pin/2. An even pin uses bits 2:0 and an odd pin uses bits 6:4. Bits 3 and 7 read as 0. The codes are 0 GPIO, 1 trigger output, 2 event request, 3 external clock, 4 receive clock 0 and 5 receive clock 1.
- R7: For each code c from 1 to 5, `owner_vld[c-1]` is 1 exactly when some pin holds code c. `owner_pin[(c-1)*PIN_W +: PIN_W]` is then the lowest such pin. Codes 0, 6 and 7 claim no function.
- R8: Bits that belong to unimplemented pins, and every pointer outside 0x62–0x65 and 0x68–0x6F, read as 0 and ignore writes.
- R9: After reset the pointer is 0x00 and every implemented pin is an input, with direction bit 1, mode 0 and stored output 0. `pad_oe` is 0 and no function has an owner.
- R10: A pad level change is seen in a data-byte read only after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write pointer and addressed byte |
| host_ptr_wr | input | 1 | Load pointer only |
| host_wdata | input | 16 | Window write value {pointer, data} |
| host_rdata | output | 16 | Window read value {pointer, byte} |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output value |
| owner_vld | output | 5 | A pin claims function code 1..5 |
| owner_pin | output | 5*PIN_W | Owning pin index per function |

## Verification
A corrupted direction or data bit appears on `pad_oe` or `pad_out` at the edge after the write. It also appears in the window readback one edge after the pointer is loaded. A wrong pointer or decode shows as a wrong upper byte or a wrong lower byte on the first read. Faults in the priority logic show on `owner_vld` and `owner_pin` as soon as the mode write lands, so the bench sets up overlapping claims and then removes the lower pin's claim. Synchroniser depth is checked edge by edge against a pad change.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;
    localparam int MAX_PINS  = 16;
    localparam int MODE_W    = 3;
    localparam int NUM_FUNCS = 5;

    localparam logic [7:0] SUB_DIR  = 8'h62;
    localparam logic [7:0] SUB_DATA = 8'h64;
    localparam logic [7:0] SUB_MODE = 8'h68;

    typedef struct packed {
        logic [7:0]                 ptr;
        logic [MAX_PINS-1:0]        dir;
        logic [MAX_PINS-1:0]        dout;
        logic [MAX_PINS*MODE_W-1:0] mode;
    } win_state_t;
endpackage

// File: rtl/gpio_win_sync.sv
module gpio_win_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = async_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.s2;

    logic [1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst_q <= 2'd0;
        else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
    end

    assert_sync_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/gpio_win_regs.sv
module gpio_win_regs
    import gpio_win_pkg::*;
#(
    parameter int NPINS = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic                    ptr_wr,
    input  logic [15:0]             wdata,
    input  logic [NPINS-1:0]        pin_sync,
    output logic [15:0]             rdata,
    output logic [NPINS-1:0]        dir_o,
    output logic [NPINS-1:0]        dout_o,
    output logic [NPINS*MODE_W-1:0] mode_o
);
    localparam logic [MAX_PINS-1:0] IMPL = MAX_PINS'((32'h1 << NPINS) - 1);

    win_state_t s_d, s_q;
    logic [MAX_PINS-1:0] lvl16;
    logic [7:0] wsel, wbyte, rbyte;

    assign lvl16 = MAX_PINS'(pin_sync);
    assign wsel  = wdata[15:8];
    assign wbyte = wdata[7:0];

    always_comb begin
        s_d = s_q;
        if (wr || ptr_wr) s_d.ptr = wsel;
        if (wr) begin
            if (wsel[7:1] == SUB_DIR[7:1]) begin
                for (int b = 0; b < 8; b++) begin
                    automatic int p = (wsel[0] ? 8 : 0) + b;
                    if (IMPL[p]) s_d.dir[p] = wbyte[b];
                end
            end
            if (wsel[7:1] == SUB_DATA[7:1]) begin
                for (int b = 0; b < 8; b++) begin
                    automatic int p = (wsel[0] ? 8 : 0) + b;
                    if (IMPL[p]) s_d.dout[p] = wbyte[b];
                end
            end
            if (wsel[7:3] == SUB_MODE[7:3]) begin
                for (int h = 0; h < 2; h++) begin
                    automatic int p = int'(wsel[2:0]) * 2 + h;
                    if (IMPL[p]) s_d.mode[p*MODE_W +: MODE_W] = wbyte[h*4 +: MODE_W];
                end
            end
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (s_q.ptr[7:1] == SUB_DIR[7:1]) begin
            for (int b = 0; b < 8; b++) begin
                automatic int p = (s_q.ptr[0] ? 8 : 0) + b;
                rbyte[b] = IMPL[p] & s_q.dir[p];
            end
        end
        if (s_q.ptr[7:1] == SUB_DATA[7:1]) begin
            for (int b = 0; b < 8; b++) begin
                automatic int p = (s_q.ptr[0] ? 8 : 0) + b;
                rbyte[b] = IMPL[p] & (s_q.dir[p] ? lvl16[p] : s_q.dout[p]);
            end
        end
        if (s_q.ptr[7:3] == SUB_MODE[7:3]) begin
            for (int h = 0; h < 2; h++) begin
                automatic int p = int'(s_q.ptr[2:0]) * 2 + h;
                if (IMPL[p]) rbyte[h*4 +: MODE_W] = s_q.mode[p*MODE_W +: MODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dir  <= IMPL;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = {s_q.ptr, rbyte};
    assign dir_o  = s_q.dir[NPINS-1:0];
    assign dout_o = s_q.dout[NPINS-1:0];
    assign mode_o = s_q.mode[NPINS*MODE_W-1:0];

    assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr || ptr_wr) |=> (rdata[15:8] == $past(wdata[15:8])));

    assert_ptr_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && !wr) |=> ($stable(dir_o) && $stable(dout_o) && $stable(mode_o)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((rdata[15:9] == 7'h31) || (rdata[15:9] == 7'h32) || (rdata[15:11] == 5'h0D))
        |-> (rdata[7:0] == 8'h00));

    assert_mode_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15:11] == 5'h0D) |-> (rdata[3] == 1'b0 && rdata[7] == 1'b0));
endmodule

// File: rtl/gpio_win_arb.sv
module gpio_win_arb
    import gpio_win_pkg::*;
#(
    parameter int NPINS = 11,
    parameter int PW    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS*MODE_W-1:0] mode_i,
    output logic [NUM_FUNCS-1:0]    vld_o,
    output logic [NUM_FUNCS*PW-1:0] pin_o
);
    always_comb begin
        vld_o = '0;
        pin_o = '0;
        for (int f = 0; f < NUM_FUNCS; f++) begin
            for (int p = NPINS - 1; p >= 0; p--) begin
                if (mode_i[p*MODE_W +: MODE_W] == MODE_W'(f + 1)) begin
                    vld_o[f]         = 1'b1;
                    pin_o[f*PW +: PW] = PW'(p);
                end
            end
        end
    end

    function automatic logic none_below(input logic [NPINS*MODE_W-1:0] m,
                                        input int code, input int lim);
        logic ok;
        ok = 1'b1;
        for (int p = 0; p < NPINS; p++)
            if (p < lim && m[p*MODE_W +: MODE_W] == MODE_W'(code)) ok = 1'b0;
        return ok;
    endfunction

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_chk
        assert_owner_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o[f] |-> ((mode_i[int'(pin_o[f*PW +: PW])*MODE_W +: MODE_W] == MODE_W'(f + 1))
                          && none_below(mode_i, f + 1, int'(pin_o[f*PW +: PW]))));
        assert_owner_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_o[f] |-> none_below(mode_i, f + 1, NPINS));
    end
endmodule

// File: rtl/gpio_win_bank.sv
module gpio_win_bank
    import gpio_win_pkg::*;
#(
    parameter int NPINS = 11,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic                       host_ptr_wr,
    input  logic [15:0]                host_wdata,
    output logic [15:0]                host_rdata,
    input  logic [NPINS-1:0]           pad_in,
    output logic [NPINS-1:0]           pad_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NUM_FUNCS-1:0]       owner_vld,
    output logic [NUM_FUNCS*PIN_W-1:0] owner_pin
);
    logic [NPINS-1:0]        lvl_sync;
    logic [NPINS-1:0]        dir;
    logic [NPINS*MODE_W-1:0] mode;

    gpio_win_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(lvl_sync)
    );

    gpio_win_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .ptr_wr(host_ptr_wr),
        .wdata(host_wdata), .pin_sync(lvl_sync), .rdata(host_rdata),
        .dir_o(dir), .dout_o(pad_out), .mode_o(mode)
    );

    gpio_win_arb #(.NPINS(NPINS), .PW(PIN_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .vld_o(owner_vld), .pin_o(owner_pin)
    );

    assign pad_oe = ~dir;

    assert_oe_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[15:8] == 8'h62) |=> (pad_oe[0] == !$past(host_wdata[0])));

    assert_out_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[15:8] == 8'h64) |=> (pad_out[0] == $past(host_wdata[0])));

    assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ptr_wr && host_wdata[15:8] == 8'h64) |=> (pad_out[1] == $past(host_wdata[1])));
endmodule

// File: tb/tb_gpio_win_bank.sv
module tb_gpio_win_bank;
    localparam int NP = 11;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_ptr_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe, pad_out;
    logic [4:0] owner_vld;
    logic [5*PW-1:0] owner_pin;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_win_bank #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ptr_wr(host_ptr_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .owner_vld(owner_vld), .owner_pin(owner_pin)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] p, logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = {p, d};
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic set_ptr(logic [7:0] p, logic [7:0] d = 8'h00);
        @(negedge clk); host_ptr_wr = 1'b1; host_wdata = {p, d};
        @(negedge clk); host_ptr_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] p, output logic [7:0] v);
        set_ptr(p);
        v = host_rdata[7:0];
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R9 rdata", host_rdata, 16'h0000);
        chk("R9 oe", pad_oe, '0);
        chk("R9 out", pad_out, '0);
        chk("R9 owner", owner_vld, 5'b0);
        rd(8'h62, v); chk("R9 dir lo", v, 8'hFF);
        rd(8'h63, v); chk("R9 dir hi", v, 8'h07);
        rd(8'h68, v); chk("R9 mode", v, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        wr_reg(8'h62, 8'hA5);
        chk("R4 oe", pad_oe[7:0], 8'h5A);
        rd(8'h62, v); chk("R4 readback", v, 8'hA5);
        chk("R1 ptr field", host_rdata[15:8], 8'h62);
        wr_reg(8'h63, 8'hFF);
        rd(8'h63, v); chk("R8 unimpl dir", v, 8'h07);
        wr_reg(8'h63, 8'h00);
        chk("R4 oe hi", pad_oe[10:8], 3'b111);
        wr_reg(8'h63, 8'hFF);
    endtask

    task automatic t_data();
        logic [7:0] v;
        wr_reg(8'h64, 8'hFF);
        chk("R5 out", pad_out[7:0], 8'hFF);
        rd(8'h64, v); chk("R5 mixed read", v, 8'h5A);
        pad_in = 11'h001;
        @(negedge clk); chk("R10 one edge", host_rdata[7:0], 8'h5A);
        @(negedge clk); chk("R10 two edges", host_rdata[7:0], 8'h5B);
        pad_in = '0;
    endtask

    task automatic t_ptronly();
        logic [7:0] v;
        set_ptr(8'h62, 8'h00);
        chk("R2 ptr", host_rdata[15:8], 8'h62);
        chk("R2 byte kept", host_rdata[7:0], 8'hA5);
        chk("R2 oe kept", pad_oe[7:0], 8'h5A);
        @(negedge clk); host_wr = 1'b1; host_ptr_wr = 1'b1; host_wdata = 16'h620F;
        @(negedge clk); host_wr = 1'b0; host_ptr_wr = 1'b0;
        rd(8'h62, v); chk("R3 both strobes", v, 8'h0F);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        wr_reg(8'h68, 8'hFF);
        rd(8'h68, v); chk("R6 packing", v, 8'h77);
        wr_reg(8'h6D, 8'hFF);
        rd(8'h6D, v); chk("R8 odd unimpl", v, 8'h07);
        chk("R7 code7 no claim", owner_vld, 5'b0);
        wr_reg(8'h6E, 8'hFF);
        rd(8'h6E, v); chk("R8 mode beyond", v, 8'h00);
        wr_reg(8'h60, 8'hFF);
        rd(8'h60, v); chk("R8 unmapped", v, 8'h00);
        wr_reg(8'h68, 8'h00);
        wr_reg(8'h6D, 8'h00);
    endtask

    task automatic t_owner();
        wr_reg(8'h6A, 8'h20);
        wr_reg(8'h69, 8'h20);
        chk("R7 evt vld", owner_vld, 5'b00010);
        chk("R7 evt lowest", owner_pin[1*PW +: PW], 4'd3);
        wr_reg(8'h69, 8'h00);
        chk("R7 evt moves", owner_pin[1*PW +: PW], 4'd5);
        wr_reg(8'h6D, 8'h05);
        wr_reg(8'h6A, 8'h27);
        chk("R7 mixed vld", owner_vld, 5'b10010);
        chk("R7 rx1 pin", owner_pin[4*PW +: PW], 4'd10);
        wr_reg(8'h68, 8'h11);
        chk("R7 trig lowest", owner_pin[0 +: PW], 4'd0);
        chk("R7 trig vld", owner_vld[0], 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_data();
        t_ptronly();
        t_mode();
        t_owner();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule